// File: doc/BRIEF.md
# Branch-Likely Resolution Unit

This unit resolves conditional branches whose delay-slot instruction is cancelled when the branch falls through. Each cycle it may accept one decoded branch operation. The operation carries the value of the tested register, four coprocessor condition lines with a two-bit selector, the address of the branch and its 16-bit word offset. One cycle later, lined up with the delay-slot stage, it reports one of two results. Either the branch is taken and fetch is redirected to the target, or the delay-slot instruction is annulled so that it commits nothing. The linking forms also request a write of the return address to register 31.

A small state machine sequences the result. **IDLE** means no result is pending. **RESOLVED** means a registered result is presented for exactly one cycle. The transitions are: *accept* (IDLE to RESOLVED when `br_valid` is high), *chain* (RESOLVED to RESOLVED when another operation arrives in the same cycle), *drain* (RESOLVED to IDLE with no new operation) and *hold* (IDLE to IDLE). Condition evaluation and address arithmetic sit in two submodules in front of the state register.

Top module: `blr_unit`

## Requirements
- R1: Operation codes on `br_op` are 0 = branch if negative, 1 = branch if non-negative, 2 = branch if negative with link, 3 = branch if non-negative with link, 4 = branch if coprocessor condition true, 5 = branch if coprocessor condition false. For codes 0 to 3, only bit 31 of `src_val` decides: the negative forms are taken when it is 1 and the non-negative forms when it is 0.
- R2: Codes 4 and 5 test `cp_cond[cp_sel]`. Code 4 is taken when that bit is 1 and code 5 when it is 0. The other condition lines have no effect.
- R3: `res_target` equals `br_pc + 4 + (sign-extended br_off shifted left by 2)`, taken modulo 2^32 with no overflow indication. It is presented in the cycle after the operation is accepted.
- R4: For an accepted legal code, exactly one of `res_taken` and `res_annul` is high in the result cycle. `res_annul` is high when the branch is not taken. The two are never high together.
- R5: Codes 2 and 3 raise `link_we` in the result cycle whether the branch is taken or not. In that cycle `link_idx` is 31 and `link_data` is `br_pc + 8` modulo 2^32. No other code raises `link_we`.
- R6: Results appear exactly one clock after `br_valid` is sampled high and last one cycle. Operations accepted on consecutive cycles give results on consecutive cycles. With no operation accepted, `res_taken`, `res_annul` and `link_we` are low.
- R7: Codes 6 and 7 are reserved. They raise none of `res_taken`, `res_annul` and `link_we`.
- R8: While `rst_n` is low, and in the cycle after it is released, `res_taken`, `res_annul` and `link_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_valid | input | 1 | A branch operation is presented |
| br_op | input | 3 | Operation code (see R1, R7) |
| cp_sel | input | 2 | Coprocessor index for codes 4 and 5 |
| src_val | input | 32 | Value of the tested register |
| cp_cond | input | 4 | Coprocessor condition lines |
| br_pc | input | 32 | Address of the branch instruction |
| br_off | input | 16 | Signed word offset |
| res_taken | output | 1 | Redirect fetch to `res_target` |
| res_annul | output | 1 | Cancel the delay-slot instruction |
| res_target | output | 32 | Branch target address |
| link_we | output | 1 | Write the return address |
| link_idx | output | 5 | Destination register of the link write |
| link_data | output | 32 | Return address |

## Verification
The bench tests the sign boundary with zero, -1, the most negative value and values whose low bits are set. A design that compares the whole word, or reads a bit other than 31, takes the wrong direction on one of these. It checks targets for negative offsets and for an address close to 2^32, where a design that adds the raw offset or forgets the delay-slot increment reports a wrong target. It checks linking forms on the fall-through path, where a design that gates the link write with the taken flag drops the return address. It also sends back-to-back operations and deselected condition lines, which catch a sequencer that loses a result and a selector that reads the wrong line.

// File: rtl/blr_pkg.sv
package blr_pkg;
    typedef enum logic [2:0] {
        OP_LTZ      = 3'd0,
        OP_GEZ      = 3'd1,
        OP_LTZ_LINK = 3'd2,
        OP_GEZ_LINK = 3'd3,
        OP_CP_TRUE  = 3'd4,
        OP_CP_FALSE = 3'd5,
        OP_RSV6     = 3'd6,
        OP_RSV7     = 3'd7
    } blr_op_e;

    typedef enum logic {
        ST_IDLE     = 1'b0,
        ST_RESOLVED = 1'b1
    } blr_state_e;
endpackage

// File: rtl/blr_cond.sv
module blr_cond
    import blr_pkg::*;
#(
    parameter int CP_N = 4,
    localparam int SEL_W = (CP_N > 1) ? $clog2(CP_N) : 1
) (
    input  blr_op_e          op,
    input  logic             sign_bit,
    input  logic [CP_N-1:0]  cp_cond,
    input  logic [SEL_W-1:0] cp_sel,
    output logic             taken,
    output logic             legal,
    output logic             is_link
);
    logic cp_line;

    assign cp_line = cp_cond[cp_sel];

    always_comb begin
        taken   = 1'b0;
        legal   = 1'b1;
        is_link = 1'b0;
        unique case (op)
            OP_LTZ:      taken = sign_bit;
            OP_GEZ:      taken = ~sign_bit;
            OP_LTZ_LINK: begin taken = sign_bit;  is_link = 1'b1; end
            OP_GEZ_LINK: begin taken = ~sign_bit; is_link = 1'b1; end
            OP_CP_TRUE:  taken = cp_line;
            OP_CP_FALSE: taken = ~cp_line;
            OP_RSV6, OP_RSV7: legal = 1'b0;
        endcase
    end

    always_comb begin
        if (legal && !is_link && op == OP_LTZ)
            a_r1_ltz_sign: assert (taken == sign_bit);
    end
endmodule

// File: rtl/blr_addr.sv
module blr_addr #(
    parameter int AW    = 32,
    parameter int OFF_W = 16,
    localparam int EXT_W = AW - OFF_W - 2
) (
    input  logic [AW-1:0]    pc,
    input  logic [OFF_W-1:0] off,
    output logic [AW-1:0]    target,
    output logic [AW-1:0]    link
);
    logic [AW-1:0] slot_pc;
    logic [AW-1:0] disp;

    assign slot_pc = pc + AW'(4);
    assign disp    = {{EXT_W{off[OFF_W-1]}}, off, 2'b00};
    assign target  = slot_pc + disp;
    assign link    = slot_pc + AW'(4);

    always_comb begin
        a_r5_link_step: assert (link - pc == AW'(8));
    end
endmodule

// File: rtl/blr_unit.sv
module blr_unit
    import blr_pkg::*;
#(
    parameter int AW       = 32,
    parameter int OFF_W    = 16,
    parameter int CP_N     = 4,
    parameter int REG_W    = 5,
    parameter int LINK_REG = 31,
    localparam int SEL_W = (CP_N > 1) ? $clog2(CP_N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             br_valid,
    input  logic [2:0]       br_op,
    input  logic [SEL_W-1:0] cp_sel,
    input  logic [AW-1:0]    src_val,
    input  logic [CP_N-1:0]  cp_cond,
    input  logic [AW-1:0]    br_pc,
    input  logic [OFF_W-1:0] br_off,
    output logic             res_taken,
    output logic             res_annul,
    output logic [AW-1:0]    res_target,
    output logic             link_we,
    output logic [REG_W-1:0] link_idx,
    output logic [AW-1:0]    link_data
);
    blr_state_e    state_q, state_d;
    logic          c_taken, c_legal, c_link;
    logic [AW-1:0] c_target, c_link_val;
    logic          q_taken, q_legal, q_link;
    logic [AW-1:0] q_target, q_link_val;

    blr_cond #(.CP_N(CP_N)) u_cond (
        .op       (blr_op_e'(br_op)),
        .sign_bit (src_val[AW-1]),
        .cp_cond  (cp_cond),
        .cp_sel   (cp_sel),
        .taken    (c_taken),
        .legal    (c_legal),
        .is_link  (c_link)
    );

    blr_addr #(.AW(AW), .OFF_W(OFF_W)) u_addr (
        .pc     (br_pc),
        .off    (br_off),
        .target (c_target),
        .link   (c_link_val)
    );

    always_comb begin
        unique case (state_q)
            ST_IDLE:     state_d = br_valid ? ST_RESOLVED : ST_IDLE;
            ST_RESOLVED: state_d = br_valid ? ST_RESOLVED : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            q_taken    <= 1'b0;
            q_legal    <= 1'b0;
            q_link     <= 1'b0;
            q_target   <= '0;
            q_link_val <= '0;
        end else begin
            state_q <= state_d;
            if (br_valid) begin
                q_taken    <= c_taken;
                q_legal    <= c_legal;
                q_link     <= c_link;
                q_target   <= c_target;
                q_link_val <= c_link_val;
            end
        end
    end

    always_comb begin
        res_taken  = 1'b0;
        res_annul  = 1'b0;
        link_we    = 1'b0;
        link_idx   = '0;
        res_target = q_target;
        link_data  = q_link_val;
        unique case (state_q)
            ST_IDLE: ;
            ST_RESOLVED: begin
                res_taken = q_legal & q_taken;
                res_annul = q_legal & ~q_taken;
                link_we   = q_legal & q_link;
                if (link_we) link_idx = REG_W'(LINK_REG);
            end
        endcase
    end

    a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(res_taken && res_annul));

    a_r6_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && br_op < 3'd6) |=> (res_taken ^ res_annul));

    a_r6_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !br_valid |=> (!res_taken && !res_annul && !link_we));

    a_r7_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && br_op >= 3'd6) |=> (!res_taken && !res_annul && !link_we));

    a_r5_link_reg: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |-> (link_idx == REG_W'(LINK_REG)));

    a_r5_link_data: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && (br_op == 3'd2 || br_op == 3'd3)) |=>
        (link_we && link_data == $past(br_pc) + AW'(8)));

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        br_valid |=> (res_target == $past(br_pc) + AW'(4)
                      + {{(AW-OFF_W-2){$past(br_off[OFF_W-1])}}, $past(br_off), 2'b00}));
endmodule

// File: tb/blr_unit_tb.sv
module blr_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        br_valid;
    logic [2:0]  br_op;
    logic [1:0]  cp_sel;
    logic [31:0] src_val;
    logic [3:0]  cp_cond;
    logic [31:0] br_pc;
    logic [15:0] br_off;
    logic        res_taken, res_annul, link_we;
    logic [31:0] res_target, link_data;
    logic [4:0]  link_idx;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    blr_unit u_dut (
        .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_op(br_op),
        .cp_sel(cp_sel), .src_val(src_val), .cp_cond(cp_cond),
        .br_pc(br_pc), .br_off(br_off), .res_taken(res_taken),
        .res_annul(res_annul), .res_target(res_target), .link_we(link_we),
        .link_idx(link_idx), .link_data(link_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic exp_taken(input logic [2:0] op, input logic [31:0] v,
                                       input logic [3:0] cc, input logic [1:0] s);
        case (op)
            3'd0, 3'd2: return v[31];
            3'd1, 3'd3: return !v[31];
            3'd4:       return cc[s];
            3'd5:       return !cc[s];
            default:    return 1'b0;
        endcase
    endfunction

    task automatic drive(input logic [2:0] op, input logic [1:0] s, input logic [31:0] v,
                         input logic [3:0] cc, input logic [31:0] pc, input logic [15:0] off);
        br_valid = 1'b1; br_op = op; cp_sel = s; src_val = v;
        cp_cond = cc; br_pc = pc; br_off = off;
    endtask

    task automatic expect_res(input string req, input logic [2:0] op, input logic [1:0] s,
                              input logic [31:0] v, input logic [3:0] cc,
                              input logic [31:0] pc, input logic [15:0] off);
        logic legal = (op < 3'd6);
        logic tk    = exp_taken(op, v, cc, s);
        logic lk    = (op == 3'd2 || op == 3'd3);
        chk({req, " taken"}, 32'(res_taken), 32'(legal & tk));
        chk({req, " annul"}, 32'(res_annul), 32'(legal & !tk));
        chk({req, " link_we"}, 32'(link_we), 32'(lk));
        if (legal)
            chk({req, " target"}, res_target, pc + 32'd4 + {{14{off[15]}}, off, 2'b00});
        if (lk) begin
            chk({req, " link_idx"}, 32'(link_idx), 32'd31);
            chk({req, " link_data"}, link_data, pc + 32'd8);
        end
    endtask

    task automatic one(input string req, input logic [2:0] op, input logic [1:0] s,
                       input logic [31:0] v, input logic [3:0] cc,
                       input logic [31:0] pc, input logic [15:0] off);
        @(negedge clk);
        drive(op, s, v, cc, pc, off);
        @(negedge clk);
        br_valid = 1'b0;
        expect_res(req, op, s, v, cc, pc, off);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; br_valid = 1'b0; br_op = '0; cp_sel = '0;
        src_val = '0; cp_cond = '0; br_pc = '0; br_off = '0;
        repeat (3) @(negedge clk);
        chk("R8 taken in reset", 32'(res_taken), 0);
        chk("R8 annul in reset", 32'(res_annul), 0);
        chk("R8 link_we in reset", 32'(link_we), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 flags after release", {29'd0, res_taken, res_annul, link_we}, 0);
    endtask

    task automatic t_sign();
        one("R1 ltz neg", 3'd0, 2'd0, 32'hFFFF_FFFF, 4'h0, 32'h0000_1000, 16'h0004);
        one("R1 ltz zero", 3'd0, 2'd0, 32'h0, 4'h0, 32'h0000_1000, 16'h0004);
        one("R1 ltz lowbits", 3'd0, 2'd0, 32'h7FFF_FFFF, 4'h0, 32'h0000_2000, 16'h0010);
        one("R1 gez zero", 3'd1, 2'd0, 32'h0, 4'h0, 32'h0000_3000, 16'h0001);
        one("R1 gez minint", 3'd1, 2'd0, 32'h8000_0000, 4'h0, 32'h0000_3000, 16'h0001);
        one("R1 gez pos", 3'd1, 2'd0, 32'h0000_0001, 4'h0, 32'h0000_3000, 16'h0001);
    endtask

    task automatic t_cp();
        for (int i = 0; i < 4; i++) begin
            one("R2 true sel", 3'd4, 2'(i), 32'h8000_0000, 4'(1 << i), 32'h100, 16'h2);
            one("R2 true other lines", 3'd4, 2'(i), 32'h0, ~4'(1 << i), 32'h100, 16'h2);
            one("R2 false sel", 3'd5, 2'(i), 32'h0, ~4'(1 << i), 32'h200, 16'h3);
        end
    endtask

    task automatic t_target();
        one("R3 neg offset", 3'd1, 2'd0, 32'h0, 4'h0, 32'h0000_4000, 16'hFFFE);
        one("R3 wrap up", 3'd1, 2'd0, 32'h0, 4'h0, 32'hFFFF_FFF8, 16'h0010);
        one("R3 wrap down", 3'd0, 2'd0, 32'hF000_0000, 4'h0, 32'h0000_0004, 16'h8000);
        one("R4 annul with target", 3'd0, 2'd0, 32'h1, 4'h0, 32'h1234_5678, 16'h7FFF);
    endtask

    task automatic t_link();
        one("R5 link taken", 3'd2, 2'd0, 32'h8000_0001, 4'h0, 32'h0040_0000, 16'h0020);
        one("R5 link not taken", 3'd2, 2'd0, 32'h0000_0001, 4'h0, 32'h0040_0100, 16'h0020);
        one("R5 gez link not taken", 3'd3, 2'd0, 32'hFFFF_0000, 4'h0, 32'h0040_0200, 16'hFFF0);
        one("R5 link wrap", 3'd3, 2'd0, 32'h0, 4'h0, 32'hFFFF_FFFC, 16'h0001);
    endtask

    task automatic t_reserved();
        one("R7 code6", 3'd6, 2'd1, 32'h8000_0000, 4'hF, 32'h500, 16'h1);
        one("R7 code7", 3'd7, 2'd2, 32'h0, 4'h0, 32'h600, 16'h1);
    endtask

    task automatic t_b2b();
        @(negedge clk);
        drive(3'd0, 2'd0, 32'h8000_0000, 4'h0, 32'h700, 16'h4);
        @(negedge clk);
        expect_res("R6 b2b first", 3'd0, 2'd0, 32'h8000_0000, 4'h0, 32'h700, 16'h4);
        drive(3'd3, 2'd0, 32'h8000_0000, 4'h0, 32'h704, 16'h8);
        @(negedge clk);
        expect_res("R6 b2b second", 3'd3, 2'd0, 32'h8000_0000, 4'h0, 32'h704, 16'h8);
        br_valid = 1'b0;
        src_val = 32'h0; br_op = 3'd2;
        @(negedge clk);
        chk("R6 drained flags", {29'd0, res_taken, res_annul, link_we}, 0);
        @(negedge clk);
        chk("R6 idle flags", {29'd0, res_taken, res_annul, link_we}, 0);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_sign();
                t_cp();
                t_target();
                t_link();
                t_reserved();
                t_b2b();
            end
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        disable fork;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule